// File: doc/BRIEF.md
# Sliding Trapezoid Window Filter for a One-Bit Stream

This block turns a one-bit oversampled bit stream into an 8-bit amplitude sample that is refreshed on every clock, for oscilloscope-style capture where low timing jitter matters more than DC precision. The stream first passes a five-tap binomial smoother. That smoother is then widened by four delay-and-add stages that reuse its output instead of weighting every tap on its own. The result is a 21-tap flat-topped window whose weights sum to exactly 256. The unclamped sum is carried at 9 bits and clamped to 255, so a stream of all ones reads full scale instead of wrapping to zero.

The short binomial result is also brought out as a separate 5-bit trigger value. A capture controller can use it to detect edges with far less delay than the full window has. A valid flag shows when every tap of the window holds bits taken after reset. Decimation, trigger decisions and sample storage belong to the surrounding logic.

Top module: `tukey_window_filter`

## Requirements
- R1: After the clock edge that samples bit b(m), `trig_o` equals b(m-1) + 4·b(m-2) + 6·b(m-3) + 4·b(m-4) + b(m-5). Bits sampled before reset release, or during reset, count as 0.
- R2: `trig_o` is 5 bits wide and reaches its maximum of 16 only when those five bits are all 1.
- R3: After the edge that samples b(m), the unclamped window sum is Σ w(j)·b(m-6-j) for j = 0..20, with w = 1,4,8,12,15, then eleven taps of 16, then 15,12,8,4,1. `sample_o` equals that sum whenever it is at most 255, and it updates on every clock.
- R4: When the window sum is 256 (all 21 windowed bits are 1), `sample_o` reads 255.
- R5: When all 21 windowed bits are 0, `sample_o` reads 0.
- R6: `valid_o` is low from reset and rises after the edge that samples b(26), which is the 27th edge after reset release. It then stays high until the next reset.
- R7: While `rst_n` is low, `sample_o`, `trig_o` and `valid_o` are all 0. An assertion of reset in the middle of a stream also clears all window history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one stream bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Oversampled one-bit stream |
| sample_o | output | 8 | Clamped 21-tap window result |
| trig_o | output | 5 | Five-tap binomial result for triggering |
| valid_o | output | 1 | High once the whole window holds post-reset bits |

## Verification
A single isolated one-bit must trace the whole 21-weight impulse response, tap by tap, at the right offset. A design with a wrong stage delay would show a broken plateau or a shifted response. A long run of ones drives the sum to exactly 256: a design with an 8-bit adder or no clamp would read 0 there instead of 255. Alternating, period-three and pseudo-random streams of several densities check the arithmetic of every stage at once. The valid flag is checked for rising neither one cycle early nor one cycle late, both from power-up and after a reset in mid-stream, and that reset must leave no residue of earlier bits in the window.

// File: rtl/tukey_pkg.sv
package tukey_pkg;

  localparam int SAMPLE_W  = 8;
  localparam int ACC_W     = 9;
  localparam int KERN_TAPS = 5;
  localparam int N_STAGES  = 4;
  localparam int TRIG_W    = $clog2((1 << (KERN_TAPS - 1)) + 1);

  // Binomial coefficient n choose k, for kernel weights.
  function automatic int choose(input int n, input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) begin
      r = r * (n - i) / (i + 1);
    end
    return r;
  endfunction

  // Delay of each delay-and-add stage: 2, 2, 4, 8.
  function automatic int stage_delay(input int s);
    return (s < 2) ? 2 : (4 << (s - 2));
  endfunction

  // Largest value a stage output can hold (kernel sum doubles per stage).
  function automatic int stage_max(input int s);
    return (1 << (KERN_TAPS - 1)) << (s + 1);
  endfunction

  // Total window length.
  function automatic int window_taps();
    int t;
    t = KERN_TAPS;
    for (int s = 0; s < N_STAGES; s++) begin
      t = t + stage_delay(s);
    end
    return t;
  endfunction

  // Clamp the unsaturated sum to the sample width.
  function automatic logic [SAMPLE_W-1:0] clamp_sample(input logic [ACC_W-1:0] v);
    logic [ACC_W-1:0] lim;
    lim = ACC_W'((1 << SAMPLE_W) - 1);
    return (v > lim) ? lim[SAMPLE_W-1:0] : v[SAMPLE_W-1:0];
  endfunction

endpackage

// File: rtl/binomial_kernel.sv
module binomial_kernel
  import tukey_pkg::*;
#(
  parameter int TAPS = KERN_TAPS,
  parameter int W    = ACC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_i,
  output logic [W-1:0] sum_o
);

  localparam int PEAK = 1 << (TAPS - 1);

  logic [TAPS-1:0] sr_q;
  logic [W-1:0]    acc;
  logic [W-1:0]    sum_q;
  logic            all_ones;

  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) begin
      acc = acc + (sr_q[i] ? W'(choose(TAPS - 1, i)) : '0);
    end
  end

  assign all_ones = &sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      sum_q <= '0;
    end else begin
      sr_q  <= {sr_q[TAPS-2:0], bit_i};
      sum_q <= acc;
    end
  end

  assign sum_o = sum_q;

  AST_TRIG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    all_ones |=> (int'(sum_q) == PEAK)); // R1
  AST_TRIG_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sum_q) <= PEAK); // R2

endmodule

// File: rtl/delay_add_stage.sv
module delay_add_stage #(
  parameter int W    = 9,
  parameter int DLY  = 2,
  parameter int MAXV = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);

  logic [W-1:0] line_q [DLY];
  logic [W-1:0] out_q;
  logic [W-1:0] tap_old;

  assign tap_old = line_q[DLY-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DLY; i++) begin
        line_q[i] <= '0;
      end
      out_q <= '0;
    end else begin
      for (int i = DLY - 1; i > 0; i--) begin
        line_q[i] <= line_q[i-1];
      end
      line_q[0] <= in_i;
      out_q     <= in_i + tap_old;
    end
  end

  assign out_o = out_q;

  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(out_q) <= MAXV); // R3

endmodule

// File: rtl/sat_output.sv
module sat_output
  import tukey_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ACC_W-1:0]    sum_i,
  output logic [SAMPLE_W-1:0] sample_o
);

  logic [SAMPLE_W-1:0] sample_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_q <= '0;
    else        sample_q <= clamp_sample(sum_i);
  end

  assign sample_o = sample_q;

endmodule

// File: rtl/tukey_window_filter.sv
module tukey_window_filter
  import tukey_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic [TRIG_W-1:0]   trig_o,
  output logic                valid_o
);

  localparam int WIN  = window_taps();
  localparam int FILL = WIN + N_STAGES + 2;
  localparam int CW   = $clog2(FILL + 1);
  localparam logic [ACC_W-1:0] FULL_SUM = ACC_W'(stage_max(N_STAGES - 1));

  logic [ACC_W-1:0] stage_w [N_STAGES+1];
  logic [CW-1:0]    fill_q;
  logic             win_full;

  binomial_kernel #(.TAPS(KERN_TAPS), .W(ACC_W)) u_kernel (
    .clk  (clk),
    .rst_n(rst_n),
    .bit_i(bit_i),
    .sum_o(stage_w[0])
  );

  generate
    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
      delay_add_stage #(
        .W   (ACC_W),
        .DLY (stage_delay(s)),
        .MAXV(stage_max(s))
      ) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .in_i (stage_w[s]),
        .out_o(stage_w[s+1])
      );
    end
  endgenerate

  sat_output u_sat (
    .clk     (clk),
    .rst_n   (rst_n),
    .sum_i   (stage_w[N_STAGES]),
    .sample_o(sample_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   fill_q <= '0;
    else if (fill_q != CW'(FILL)) fill_q <= fill_q + 1'b1;
  end

  assign win_full = (fill_q == CW'(FILL));
  assign valid_o  = win_full;
  assign trig_o   = stage_w[0][TRIG_W-1:0];

  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_w[N_STAGES] == FULL_SUM) |=> (sample_o == '1)); // R4
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o); // R6
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_w[N_STAGES] == '0) |=> (sample_o == '0)); // R5

endmodule

// File: tb/tukey_window_filter_tb.sv
`timescale 1ns/1ps
module tukey_window_filter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_i = 1'b0;
  logic [7:0] sample_o;
  logic [4:0] trig_o;
  logic       valid_o;

  int n_vec = 0;
  int n_bad = 0;
  int k_edge = 0;
  bit done = 1'b0;
  bit hist [0:4095];
  logic [15:0] lfsr = 16'hACE1;

  int w [21] = '{1, 4, 8, 12, 15,
                 16, 16, 16, 16, 16, 16, 16, 16, 16, 16, 16,
                 15, 12, 8, 4, 1};
  int kw [5] = '{1, 4, 6, 4, 1};

  always #5 clk = ~clk;

  tukey_window_filter u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_i   (bit_i),
    .sample_o(sample_o),
    .trig_o  (trig_o),
    .valid_o (valid_o)
  );

  function automatic int h(input int i);
    return (i < 0) ? 0 : int'(hist[i]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s edge=%0d actual=%0d expected=%0d", req, k_edge, act, exp);
    end
  endtask

  // Apply one bit at a negedge, clock it, then check at the next negedge.
  task automatic step(input bit b);
    int raw;
    int et;
    int es;
    bit_i = b;
    hist[k_edge] = b;
    @(posedge clk);
    @(negedge clk);
    et = 0;
    for (int i = 0; i < 5; i++) et += kw[i] * h(k_edge - 1 - i);
    raw = 0;
    for (int j = 0; j < 21; j++) raw += w[j] * h(k_edge - 6 - j);
    es = (raw > 255) ? 255 : raw;
    check((et == 16) ? "R2" : "R1", int'(trig_o), et);
    if (raw >= 256)    check("R4", int'(sample_o), es);
    else if (raw == 0) check("R5", int'(sample_o), es);
    else               check("R3", int'(sample_o), es);
    check("R6", int'(valid_o), (k_edge >= 26) ? 1 : 0);
    k_edge++;
  endtask

  task automatic reset_run();
    rst_n = 1'b0;
    bit_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", int'(sample_o), 0);
    check("R7", int'(trig_o), 0);
    check("R7", int'(valid_o), 0);
    for (int i = 0; i < 4096; i++) hist[i] = 1'b0;
    k_edge = 0;
    rst_n = 1'b1;
  endtask

  task automatic rand_bits(input int n, input int dens);
    bit b;
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (dens)
        0: b = lfsr[0] & lfsr[5];
        1: b = lfsr[0];
        default: b = lfsr[0] | lfsr[5];
      endcase
      step(b);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    reset_run();
    // R3: isolated impulse traces the window
    step(1'b1);
    for (int i = 0; i < 40; i++) step(1'b0);
    // R4: full-scale run reaches sum 256
    for (int i = 0; i < 60; i++) step(1'b1);
    // R5: zeros flush to 0
    for (int i = 0; i < 40; i++) step(1'b0);
    // R3: alternating and period-three densities
    for (int i = 0; i < 80; i++) step(i[0]);
    for (int i = 0; i < 60; i++) step((i % 3) == 0);
    for (int i = 0; i < 60; i++) step((i % 3) != 0);
    rand_bits(600, 0);
    rand_bits(600, 1);
    rand_bits(600, 2);
    // R7: mid-stream reset clears history, R6 fill timing again
    reset_run();
    rand_bits(200, 1);
    for (int i = 0; i < 40; i++) step(1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule